// File: doc/BRIEF.md
# UART Interrupt Cause and Status Collector

This block sits between a serial port's datapath and its host bus. It collects the interrupt causes of the port into one 32-bit status word: errors on the receive line, a receive request, a receive character timeout, a transmit-space request, and changes on the four modem handshake inputs. The word also carries the current line-status levels, the modem levels and their change flags, and the receive fill count.

Every cause has its own sticky bit in a 5-bit identification field. Any mix of causes can be pending at the same time. The interrupt line is high while any cause bit is set. The host reads the word, handles every cause it sees, and writes the handled cause bits back as ones to clear them. Four enable inputs decide which sources may latch a cause.

The modem inputs arrive asynchronously. They pass through a two-flop synchronizer before change detection.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, the identification field [4:0] and the modem change flags [11:8] are zero and `irq_o` is low.
- R2: Each identification bit is set by its own source, and the bit then stays set until it is cleared. The mapping is: bit0 line error, bit1 receive request (`rx_req_i`), bit2 character timeout (`rx_tmo_i`), bit3 transmit space (`tx_req_i`), bit4 modem change. The bit is latched on the clock edge at which a rising source is first seen, and it is visible in the following cycle.
- R3: The enables are `irq_en_i` bit0 (receive request and timeout), bit1 (transmit space), bit2 (line error) and bit3 (modem change). A rising source whose enable is low latches nothing. Setting the enable later, while the source stays high, also latches nothing.
- R4: Any number of identification bits can be set together, and all of them are reported. `irq_o` is the OR of bits [4:0].
- R5: A write (`clr_we_i`) clears exactly those identification bits for which `clr_data_i[4:0]` holds a one, and leaves every other bit unchanged.
- R6: If a cause is set and cleared in the same cycle, the set wins and the bit stays set.
- R7: Bits [23:16] show `line_i` bit for bit. Within `line_i`, bit0 is data ready, bit1 overrun, bit2 parity, bit3 framing, bit4 break, bit5 holding empty, bit6 transmitter empty and bit7 receive FIFO error. The line-error cause rises only when the OR of bits 1, 2, 3, 4 and 7 rises. Bits 0, 5 and 6 never raise it.
- R8: `modem_i` is ordered bit0 CTS, bit1 DSR, bit2 RI, bit3 DCD. Status bit 12+i shows the synchronized level of input i two edges after that input changes. Change flag 8+i, and cause bit4 if it is enabled, are set one edge later than the level.
- R9: A clear write with `clr_data_i[4]` set also zeroes all four change flags, whatever the modem enable is. A change seen in the same cycle wins over the clear.
- R10: The receive count `rx_cnt_i` appears with bits [7:0] at status [31:24] and bits [9:8] at status [7:6]. Status bit 5 reads zero. Bits [7:6] of a clear write have no effect on any status bit.
- R11: A source that stays high after its cause is cleared does not set the cause again. It must first fall and then rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| line_i | input | 8 | Line-status levels from the receiver and transmitter |
| rx_req_i | input | 1 | Receive buffer request level |
| rx_tmo_i | input | 1 | Character timeout level |
| tx_req_i | input | 1 | Transmit space available level |
| modem_i | input | 4 | Asynchronous modem inputs CTS, DSR, RI, DCD |
| rx_cnt_i | input | 10 | Receive buffer fill count |
| irq_en_i | input | 4 | Cause enables |
| clr_we_i | input | 1 | Clear write strobe for the low status byte |
| clr_data_i | input | 8 | Clear write data, ones clear cause bits |
| status_o | output | 32 | Assembled status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions rely on a few properties of the inputs:
- Every source input other than `modem_i` is synchronous to `clk`.
- `clr_we_i` is a single-cycle strobe.
- The enables stay steady within a cycle.

The stimulus drives every input on the falling edge. Each cycle it draws random levels with low toggle rates, so that sources stay high across several cycles and the no-retrigger rule is exercised. It also issues clear writes with random masks, including the two unused high bits. Directed sequences cover the following cases:
- set and clear colliding in one cycle;
- changing an enable while its source is held high;
- line-status bits that must not raise a cause;
- the three-edge latency of the modem inputs.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NUM_CAUSE = 5;
    localparam int C_LINE    = 0;
    localparam int C_RXREQ   = 1;
    localparam int C_RXTMO   = 2;
    localparam int C_TXREQ   = 3;
    localparam int C_MODEM   = 4;

    localparam int EN_RX     = 0;
    localparam int EN_TX     = 1;
    localparam int EN_LINE   = 2;
    localparam int EN_MODEM  = 3;

    // line_i bits that count as receive errors
    localparam logic [7:0] LINE_ERR_MASK = 8'b1001_1110;
endpackage

// File: rtl/uart_modem_sync.sv
module uart_modem_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic         clr_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] delta_o,
    output logic         chg_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             last;
        logic [W-1:0]             delta;
    } msync_t;

    msync_t st_d, st_q;
    logic [W-1:0] diff;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_i;
        for (int k = 1; k < STAGES; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
        diff          = st_q.chain[STAGES-1] ^ st_q.last;
        st_d.last     = st_q.chain[STAGES-1];
        st_d.delta    = (clr_i ? '0 : st_q.delta) | diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.chain[STAGES-1];
    assign delta_o = st_q.delta;
    assign chg_o   = |diff;

    AST_DELTA_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |=> (delta_o != '0));                      // R8
    AST_DELTA_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !chg_o) |=> (delta_o == '0));          // R9
endmodule

// File: rtl/uart_cause_latch.sv
module uart_cause_latch #(
    parameter bit EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic en_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } cause_t;

    cause_t st_d, st_q;
    logic   set_w;

    generate
        if (EDGE) begin : g_edge
            assign set_w = en_i & src_i & ~st_q.prev;
        end else begin : g_pulse
            assign set_w = en_i & src_i;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_i;
        st_d.pend = (st_q.pend & ~clr_i) | set_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        set_w |=> pend_o);                               // R2
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_w) |=> !pend_o);                  // R5
    AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_w) |=> $stable(pend_o));         // R11
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int MODEM_W     = 4,
    parameter int RXCNT_W     = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         line_i,
    input  logic               rx_req_i,
    input  logic               rx_tmo_i,
    input  logic               tx_req_i,
    input  logic [MODEM_W-1:0] modem_i,
    input  logic [RXCNT_W-1:0] rx_cnt_i,
    input  logic [3:0]         irq_en_i,
    input  logic               clr_we_i,
    input  logic [7:0]         clr_data_i,
    output logic [31:0]        status_o,
    output logic               irq_o
);
    localparam int CNT_LO_W = 8;
    localparam int CNT_HI_W = RXCNT_W - CNT_LO_W;

    logic [NUM_CAUSE-1:0] src_v, en_v, clr_v, pend_v;
    logic [MODEM_W-1:0]   m_level, m_delta;
    logic                 m_chg;
    logic                 modem_clr;

    assign clr_v     = clr_we_i ? clr_data_i[NUM_CAUSE-1:0] : '0;
    assign modem_clr = clr_v[C_MODEM];

    uart_modem_sync #(.W(MODEM_W), .STAGES(SYNC_STAGES)) u_msync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (modem_i),
        .clr_i   (modem_clr),
        .level_o (m_level),
        .delta_o (m_delta),
        .chg_o   (m_chg)
    );

    always_comb begin
        src_v          = '0;
        en_v           = '0;
        src_v[C_LINE]  = |(line_i & LINE_ERR_MASK);
        src_v[C_RXREQ] = rx_req_i;
        src_v[C_RXTMO] = rx_tmo_i;
        src_v[C_TXREQ] = tx_req_i;
        src_v[C_MODEM] = m_chg;
        en_v[C_LINE]   = irq_en_i[EN_LINE];
        en_v[C_RXREQ]  = irq_en_i[EN_RX];
        en_v[C_RXTMO]  = irq_en_i[EN_RX];
        en_v[C_TXREQ]  = irq_en_i[EN_TX];
        en_v[C_MODEM]  = irq_en_i[EN_MODEM];
    end

    // the modem cause is fed by a change pulse, so it is level-latched
    generate
        for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_cause
            uart_cause_latch #(.EDGE(i != C_MODEM)) u_latch (
                .clk    (clk),
                .rst_n  (rst_n),
                .src_i  (src_v[i]),
                .en_i   (en_v[i]),
                .clr_i  (clr_v[i]),
                .pend_o (pend_v[i])
            );
        end
    endgenerate

    always_comb begin
        status_o        = '0;
        status_o[4:0]   = pend_v;
        status_o[7:6]   = rx_cnt_i[RXCNT_W-1 -: CNT_HI_W];
        status_o[11:8]  = m_delta;
        status_o[15:12] = m_level;
        status_o[23:16] = line_i;
        status_o[31:24] = rx_cnt_i[CNT_LO_W-1:0];
    end

    assign irq_o = |pend_v;

    AST_NO_IRQ_AFTER_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> !irq_o);                        // R1
    AST_CNT_HIGH_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |-> (status_o[7:6] == rx_cnt_i[9:8]));  // R10
endmodule

// File: tb/sim_uart_irq_status.sv
module sim_uart_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  line_i = '0;
    logic        rx_req_i = 1'b0, rx_tmo_i = 1'b0, tx_req_i = 1'b0;
    logic [3:0]  modem_i = '0;
    logic [9:0]  rx_cnt_i = '0;
    logic [3:0]  irq_en_i = '0;
    logic        clr_we_i = 1'b0;
    logic [7:0]  clr_data_i = '0;
    logic [31:0] status_o;
    logic        irq_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_irq_status u0 (.*);

    // reference state
    logic [4:0] m_cause = '0;
    logic [3:0] m_prev = '0, m_s1 = '0, m_s2 = '0, m_s3 = '0, m_delta = '0;

    function automatic logic [31:0] exp_status();
        return {rx_cnt_i[7:0], line_i, m_s2, m_delta, rx_cnt_i[9:8], 1'b0, m_cause};
    endfunction

    task automatic model_tick();
        logic [3:0] chg, src, rise;
        logic [4:0] set, clr;
        chg  = m_s2 ^ m_s3;
        src  = {tx_req_i, rx_tmo_i, rx_req_i, |(line_i & 8'h9E)};
        rise = src & ~m_prev;
        set  = {(|chg) & irq_en_i[3], rise[3] & irq_en_i[1], rise[2] & irq_en_i[0],
                rise[1] & irq_en_i[0], rise[0] & irq_en_i[2]};
        clr  = clr_we_i ? clr_data_i[4:0] : 5'b0;
        m_cause = (m_cause & ~clr) | set;
        m_delta = (clr[4] ? 4'b0 : m_delta) | chg;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = modem_i; m_prev = src;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_tick();
        @(negedge clk);
        check(tag, status_o, exp_status());
        check(tag, {31'b0, irq_o}, {31'b0, |m_cause});
        clr_we_i = 1'b0;
        clr_data_i = '0;
    endtask

    task automatic clear(logic [7:0] d);
        clr_we_i = 1'b1;
        clr_data_i = d;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        check("R1", status_o, 32'h0);
        check("R1", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        step("R1");

        irq_en_i = 4'hF;
        rx_req_i = 1'b1;
        step("R2");
        check("R2", {27'b0, status_o[4:0]}, 32'h02);

        tx_req_i = 1'b1; rx_tmo_i = 1'b1;
        step("R4");
        check("R4", {27'b0, status_o[4:0]}, 32'h0E);
        check("R4", {31'b0, irq_o}, 32'h1);

        rx_cnt_i = 10'h3A5;
        clear(8'hC2);
        step("R5");
        check("R5", {27'b0, status_o[4:0]}, 32'h0C);
        check("R10", {24'b0, status_o[31:24]}, 32'hA5);
        check("R10", {29'b0, status_o[7:5]}, 32'h6);

        step("R11"); step("R11");
        check("R11", {31'b0, status_o[1]}, 32'h0);

        clear(8'h1F);
        step("R5");
        irq_en_i = 4'h0;
        rx_tmo_i = 1'b0;
        step("R3");
        rx_tmo_i = 1'b1;
        step("R3");
        irq_en_i = 4'hF;
        step("R3"); step("R3");
        check("R3", {27'b0, status_o[4:0]}, 32'h0);

        rx_req_i = 1'b0;
        step("R6");
        rx_req_i = 1'b1;
        clear(8'h02);
        step("R6");
        check("R6", {31'b0, status_o[1]}, 32'h1);
        clear(8'h1F);
        step("R6");

        line_i = 8'h61;
        step("R7");
        check("R7", {24'b0, status_o[23:16]}, 32'h61);
        check("R7", {31'b0, status_o[0]}, 32'h0);
        line_i = 8'h65;
        step("R7");
        check("R7", {31'b0, status_o[0]}, 32'h1);
        line_i = 8'h00;
        clear(8'h01);
        step("R7");

        modem_i = 4'b0001;
        step("R8");
        check("R8", {31'b0, status_o[12]}, 32'h0);
        step("R8");
        check("R8", {28'b0, status_o[15:12]}, 32'h1);
        check("R8", {28'b0, status_o[11:8]}, 32'h0);
        step("R8");
        check("R8", {28'b0, status_o[11:8]}, 32'h1);
        check("R8", {31'b0, status_o[4]}, 32'h1);

        irq_en_i = 4'h7;
        clear(8'h10);
        step("R9");
        check("R9", {28'b0, status_o[11:8]}, 32'h0);
        check("R9", {31'b0, status_o[4]}, 32'h0);
        irq_en_i = 4'hF;

        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 5) == 0) rx_req_i = ~rx_req_i;
            if ($urandom_range(0, 5) == 0) rx_tmo_i = ~rx_tmo_i;
            if ($urandom_range(0, 5) == 0) tx_req_i = ~tx_req_i;
            if ($urandom_range(0, 7) == 0) line_i = 8'($urandom);
            if ($urandom_range(0, 9) == 0) modem_i = 4'($urandom);
            if ($urandom_range(0, 19) == 0) irq_en_i = 4'($urandom);
            rx_cnt_i = 10'($urandom);
            if ($urandom_range(0, 3) == 0) clear(8'($urandom));
            step("R4");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule